// File: doc/BRIEF.md
# Pseudo-Random Background Check Timer

This block decides when the background checkers of a one-time-programmable memory controller run. A free-running 40-bit linear feedback shift register supplies raw values. Each of two channels, integrity and consistency, cuts a value down with a mask built from its own 6-bit exponent and loads the result into a down-counter. When the counter runs out, the channel raises a one-cycle request to its checker. It then waits for the checker's acknowledge before it draws the next interval. Because the intervals come from the shift register, an observer cannot predict when a check will happen.

Software sets the two exponents. A single write-enable bit, cleared by writing one, freezes both exponents until the next reset. The integrity channel covers only the hardware-config and secret partitions, and only while they are locked. The consistency channel always covers the life-cycle partition, and covers those two partitions as well when they are locked. Error indications from the checkers are turned into one-cycle alert pulses.

Top module: `bgchk_timer`

## Requirements
- R1: The interval source is a 40-bit Galois shift register that shifts right every cycle and XORs in tap mask 40'hA000140000 when the bit shifted out is 1 (polynomial x^40+x^38+x^21+x^19+1). It starts from a nonzero seed parameter and never reaches zero.
- R2: A channel's interval P is the register value ANDed with 2^N-1, where N is the channel's exponent. Exponents of 40 or more keep every bit. A result of zero is replaced by 1.
- R3: A channel loads P in the cycle after it enters its draw state and raises its request P cycles after that load. The draw state is entered when reset is released, when an acknowledge is accepted, or when a write restarts the channel. With the acknowledge held high, consecutive requests are therefore P+2 cycles apart.
- R4: A request is high for exactly one cycle. No further request is raised until the acknowledge is sampled high while the channel waits.
- R5: The integrity exponent resets to 27 and the consistency exponent resets to 30. While writes are enabled, a write (select 0 = integrity, 1 = consistency) updates the exponent and restarts that channel's interval with a fresh draw using the new value. A write that arrives while the channel is waiting for its acknowledge does not restart it.
- R6: The write-enable bit resets to 1. It is cleared only by a write with data 1; a write with data 0 has no effect. While it is 0, exponent writes neither change the exponents nor restart a channel. Only a reset sets it again.
- R7: Integrity scope bit 0 marks the hardware-config partition and bit 1 marks the secret partition; each bit is set only when that partition is locked. With neither locked, the integrity channel raises no request and holds its counter.
- R8: Consistency scope bit 0 (life-cycle) is always 1, bit 1 marks hardware-config when locked, and bit 2 marks secret when locked. The scope is captured in the cycle the request rises.
- R9: The integrity alert pulses for one cycle, in the cycle after the first cycle in which the parity error or the digest error is high. No new pulse follows while either error stays high.
- R10: The consistency alert pulses for one cycle, in the cycle after the mismatch input first goes high.
- R11: The two channels run independently. Neither a halt nor an error on one changes the requests or alerts of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| exp_wr_i | input | 1 | Exponent write strobe |
| exp_sel_i | input | 1 | Exponent select: 0 integrity, 1 consistency |
| exp_wdata_i | input | 6 | Exponent write value |
| regwen_wr_i | input | 1 | Write-enable register write strobe |
| regwen_wdata_i | input | 1 | Write-enable write data (1 clears) |
| regwen_o | output | 1 | Current write-enable bit |
| integ_exp_o | output | 6 | Current integrity exponent |
| cons_exp_o | output | 6 | Current consistency exponent |
| hw_cfg_locked_i | input | 1 | Hardware-config partition is locked |
| secret_locked_i | input | 1 | Secret partition is locked |
| integ_req_o | output | 1 | Integrity check request pulse |
| integ_scope_o | output | 2 | Partitions for the integrity check |
| integ_ack_i | input | 1 | Integrity check finished |
| cons_req_o | output | 1 | Consistency check request pulse |
| cons_scope_o | output | 3 | Partitions for the consistency check |
| cons_ack_i | input | 1 | Consistency check finished |
| integ_parity_err_i | input | 1 | Parity error from the integrity checker |
| integ_digest_err_i | input | 1 | Digest error from the integrity checker |
| cons_mismatch_i | input | 1 | Digest mismatch from the consistency checker |
| integ_alert_o | output | 1 | Integrity-mismatch alert pulse |
| cons_alert_o | output | 1 | Consistency-mismatch alert pulse |

## Verification
The bench uses exponents 0 and 1, where every interval must be exactly three cycles. A design that skipped the zero-to-one substitution would request every two cycles or stall. For larger exponents it checks that gaps stay inside the masked bound, and it checks that writes are ignored and cause no restart once the write-enable bit is cleared. It unlocks both partitions to confirm the integrity channel halts while consistency keeps running, withholds the acknowledge to catch a design that re-arms on its own, and holds error inputs high to catch alerts that repeat or that double on overlapping errors.

// File: rtl/bgchk_pkg.sv
package bgchk_pkg;
  typedef enum logic [1:0] {
    CH_DRAW  = 2'd0,
    CH_COUNT = 2'd1,
    CH_WAIT  = 2'd2
  } chan_state_e;

  localparam int unsigned IntegScopeW = 2;
  localparam int unsigned ConsScopeW  = 3;
endpackage

// File: rtl/bgchk_rst_sync.sv
module bgchk_rst_sync #(
  parameter int unsigned Stages = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [Stages-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[Stages-2:0], 1'b1};
  end

  assign rst_sync_no = sync_q[Stages-1];
endmodule

// File: rtl/bgchk_lfsr.sv
module bgchk_lfsr #(
  parameter int unsigned       Width = 40,
  parameter logic [Width-1:0]  Taps  = 40'hA000140000,
  parameter logic [Width-1:0]  Seed  = 40'h5A3C96E1D7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [Width-1:0] state_o
);
  logic [Width-1:0] state_q, state_d;

  always_comb begin
    state_d = state_q >> 1;
    if (state_q[0]) state_d = state_d ^ Taps;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= Seed;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

  // R1: the register never locks up in the all-zero state
  p_lfsr_nonzero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != '0);
  // R1: the register moves every cycle
  p_lfsr_moves_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> state_q != $past(state_q));
endmodule

// File: rtl/bgchk_chan.sv
module bgchk_chan
  import bgchk_pkg::*;
#(
  parameter int unsigned CntW   = 40,
  parameter int unsigned ExpW   = 6,
  parameter int unsigned ScopeW = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CntW-1:0]   lfsr_i,
  input  logic [ExpW-1:0]   exp_i,
  input  logic              restart_i,
  input  logic [ScopeW-1:0] scope_i,
  input  logic              ack_i,
  output logic              req_o,
  output logic [ScopeW-1:0] scope_o
);
  chan_state_e       state_q, state_d;
  logic [CntW-1:0]   cnt_q, cnt_d, mask, draw, period;
  logic [ScopeW-1:0] scope_q, scope_d;
  logic              req_q, req_d, cnt_en, scope_en, eligible;

  assign eligible = |scope_i;

  always_comb begin
    for (int i = 0; i < int'(CntW); i++) mask[i] = (i < int'(exp_i));
    draw   = lfsr_i & mask;
    period = (draw == '0) ? CntW'(1) : draw;
  end

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    cnt_en   = 1'b0;
    scope_d  = scope_q;
    scope_en = 1'b0;
    req_d    = 1'b0;
    unique case (state_q)
      CH_DRAW: begin
        if (!restart_i && eligible) begin
          cnt_d   = period;
          cnt_en  = 1'b1;
          state_d = CH_COUNT;
        end
      end
      CH_COUNT: begin
        if (restart_i) begin
          state_d = CH_DRAW;
        end else if (eligible) begin
          if (cnt_q == CntW'(1)) begin
            req_d    = 1'b1;
            scope_d  = scope_i;
            scope_en = 1'b1;
            state_d  = CH_WAIT;
          end else begin
            cnt_d  = cnt_q - CntW'(1);
            cnt_en = 1'b1;
          end
        end
      end
      CH_WAIT: begin
        if (ack_i) state_d = CH_DRAW;
      end
      default: state_d = CH_DRAW;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= CH_DRAW;
      cnt_q   <= CntW'(1);
      scope_q <= '0;
      req_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      req_q   <= req_d;
      if (cnt_en)   cnt_q   <= cnt_d;
      if (scope_en) scope_q <= scope_d;
    end
  end

  assign req_o   = req_q;
  assign scope_o = scope_q;

  // R4: request lasts one cycle
  p_req_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q |=> !req_q);
  // R4: no re-arm without acknowledge
  p_wait_for_ack_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == CH_WAIT && !ack_i) |=> (state_q == CH_WAIT && !req_q));
  // R7: a request only goes out for a nonempty scope
  p_req_scope_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q |-> scope_q != '0);
  // R7: counter frozen while nothing is eligible
  p_hold_inelig_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == CH_COUNT && !eligible && !restart_i) |=> $stable(cnt_q));
  // R2: a loaded interval is nonzero and within the mask
  p_period_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == CH_DRAW && eligible && !restart_i) |=>
      (cnt_q != '0) && ((cnt_q & ~$past(mask)) == '0 || cnt_q == CntW'(1)));
endmodule

// File: rtl/bgchk_alert.sv
module bgchk_alert #(
  parameter int unsigned NumSrc = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NumSrc-1:0] err_i,
  output logic              alert_o
);
  logic any_err, prev_q, alert_q, alert_d;

  assign any_err = |err_i;
  assign alert_d = any_err & ~prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= 1'b0;
      alert_q <= 1'b0;
    end else begin
      prev_q  <= any_err;
      alert_q <= alert_d;
    end
  end

  assign alert_o = alert_q;

  // R9/R10: alert is a single-cycle pulse
  p_alert_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alert_q |=> !alert_q);
  // R10: an alert follows a sampled error
  p_alert_cause_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alert_q |-> $past(any_err));
endmodule

// File: rtl/bgchk_timer.sv
module bgchk_timer
  import bgchk_pkg::*;
#(
  parameter int unsigned          LfsrWidth     = 40,
  parameter logic [LfsrWidth-1:0] LfsrTaps      = 40'hA000140000,
  parameter logic [LfsrWidth-1:0] LfsrSeed      = 40'h5A3C96E1D7,
  parameter int unsigned          ExpWidth      = 6,
  parameter logic [ExpWidth-1:0]  IntegExpReset = 6'd27,
  parameter logic [ExpWidth-1:0]  ConsExpReset  = 6'd30
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   exp_wr_i,
  input  logic                   exp_sel_i,
  input  logic [ExpWidth-1:0]    exp_wdata_i,
  input  logic                   regwen_wr_i,
  input  logic                   regwen_wdata_i,
  output logic                   regwen_o,
  output logic [ExpWidth-1:0]    integ_exp_o,
  output logic [ExpWidth-1:0]    cons_exp_o,
  input  logic                   hw_cfg_locked_i,
  input  logic                   secret_locked_i,
  output logic                   integ_req_o,
  output logic [IntegScopeW-1:0] integ_scope_o,
  input  logic                   integ_ack_i,
  output logic                   cons_req_o,
  output logic [ConsScopeW-1:0]  cons_scope_o,
  input  logic                   cons_ack_i,
  input  logic                   integ_parity_err_i,
  input  logic                   integ_digest_err_i,
  input  logic                   cons_mismatch_i,
  output logic                   integ_alert_o,
  output logic                   cons_alert_o
);
  logic                   rst_n;
  logic [LfsrWidth-1:0]   lfsr;
  logic                   regwen_q, regwen_d;
  logic [ExpWidth-1:0]    integ_exp_q, cons_exp_q;
  logic                   integ_wr, cons_wr;
  logic [IntegScopeW-1:0] integ_scope_in;
  logic [ConsScopeW-1:0]  cons_scope_in;

  bgchk_rst_sync #(.Stages(2)) u_rst_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .rst_sync_no(rst_n));

  bgchk_lfsr #(.Width(LfsrWidth), .Taps(LfsrTaps), .Seed(LfsrSeed)) u_lfsr (
    .clk_i(clk_i), .rst_ni(rst_n), .state_o(lfsr));

  // Configuration registers: next-state then storage
  always_comb begin
    regwen_d = regwen_q;
    if (regwen_wr_i && regwen_wdata_i) regwen_d = 1'b0;
    integ_wr = exp_wr_i & regwen_q & ~exp_sel_i;
    cons_wr  = exp_wr_i & regwen_q &  exp_sel_i;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      regwen_q    <= 1'b1;
      integ_exp_q <= IntegExpReset;
      cons_exp_q  <= ConsExpReset;
    end else begin
      regwen_q <= regwen_d;
      if (integ_wr) integ_exp_q <= exp_wdata_i;
      if (cons_wr)  cons_exp_q  <= exp_wdata_i;
    end
  end

  assign regwen_o    = regwen_q;
  assign integ_exp_o = integ_exp_q;
  assign cons_exp_o  = cons_exp_q;

  assign integ_scope_in = {secret_locked_i, hw_cfg_locked_i};
  assign cons_scope_in  = {secret_locked_i, hw_cfg_locked_i, 1'b1};

  bgchk_chan #(.CntW(LfsrWidth), .ExpW(ExpWidth), .ScopeW(IntegScopeW)) u_integ (
    .clk_i(clk_i), .rst_ni(rst_n), .lfsr_i(lfsr), .exp_i(integ_exp_q),
    .restart_i(integ_wr), .scope_i(integ_scope_in), .ack_i(integ_ack_i),
    .req_o(integ_req_o), .scope_o(integ_scope_o));

  bgchk_chan #(.CntW(LfsrWidth), .ExpW(ExpWidth), .ScopeW(ConsScopeW)) u_cons (
    .clk_i(clk_i), .rst_ni(rst_n), .lfsr_i(lfsr), .exp_i(cons_exp_q),
    .restart_i(cons_wr), .scope_i(cons_scope_in), .ack_i(cons_ack_i),
    .req_o(cons_req_o), .scope_o(cons_scope_o));

  bgchk_alert #(.NumSrc(2)) u_integ_alert (
    .clk_i(clk_i), .rst_ni(rst_n),
    .err_i({integ_digest_err_i, integ_parity_err_i}), .alert_o(integ_alert_o));

  bgchk_alert #(.NumSrc(1)) u_cons_alert (
    .clk_i(clk_i), .rst_ni(rst_n),
    .err_i(cons_mismatch_i), .alert_o(cons_alert_o));

  // R6: write-enable never comes back without reset
  p_regwen_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_n)
    !regwen_q |=> !regwen_q);
  // R6: exponents frozen once writes are disabled
  p_exp_frozen_r6: assert property (@(posedge clk_i) disable iff (!rst_n)
    !regwen_q |=> ($stable(integ_exp_q) && $stable(cons_exp_q)));
  // R8: life-cycle partition always in the consistency scope
  p_cons_lc_scope_r8: assert property (@(posedge clk_i) disable iff (!rst_n)
    cons_req_o |-> cons_scope_o[0]);
endmodule

// File: tb/tb_bgchk_timer.sv
module tb_bgchk_timer;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 5;
  localparam int TV_EXP [NV]   = '{0, 1, 2, 4, 6};
  localparam int TV_HW  [NV]   = '{1, 0, 1, 1, 0};
  localparam int TV_SEC [NV]   = '{0, 1, 1, 1, 1};
  localparam int TV_MIN [NV]   = '{3, 3, 3, 3, 3};
  localparam int TV_MAX [NV]   = '{3, 3, 5, 17, 65};
  localparam int TV_SCOPE [NV] = '{1, 2, 3, 3, 2};

  logic clk = 1'b0, rst_n = 1'b0;
  logic exp_wr = 0, exp_sel = 0, regwen_wr = 0, regwen_wdata = 0;
  logic [5:0] exp_wdata = '0, integ_exp, cons_exp;
  logic regwen, hw_lk = 0, sec_lk = 0;
  logic integ_req, cons_req, integ_ack = 1, cons_ack = 1;
  logic [1:0] integ_scope;
  logic [2:0] cons_scope;
  logic par_err = 0, dig_err = 0, cmis = 0, integ_alert, cons_alert;
  int n_tests = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bgchk_timer dut (
    .clk_i(clk), .rst_ni(rst_n), .exp_wr_i(exp_wr), .exp_sel_i(exp_sel),
    .exp_wdata_i(exp_wdata), .regwen_wr_i(regwen_wr), .regwen_wdata_i(regwen_wdata),
    .regwen_o(regwen), .integ_exp_o(integ_exp), .cons_exp_o(cons_exp),
    .hw_cfg_locked_i(hw_lk), .secret_locked_i(sec_lk),
    .integ_req_o(integ_req), .integ_scope_o(integ_scope), .integ_ack_i(integ_ack),
    .cons_req_o(cons_req), .cons_scope_o(cons_scope), .cons_ack_i(cons_ack),
    .integ_parity_err_i(par_err), .integ_digest_err_i(dig_err),
    .cons_mismatch_i(cmis), .integ_alert_o(integ_alert), .cons_alert_o(cons_alert));

  task automatic chk(string tag, longint act, longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk_rng(string tag, longint act, longint lo, longint hi);
    n_tests++;
    if (act < lo || act > hi) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d..%0d", tag, act, lo, hi);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  function automatic logic req_of(int ch);
    return (ch != 0) ? cons_req : integ_req;
  endfunction

  // counts negedges until the selected request is seen, up to limit
  task automatic wait_req(int ch, int limit, output int n);
    n = 0;
    for (int k = 0; k < limit; k++) begin
      tick();
      n++;
      if (req_of(ch)) return;
    end
    n = limit + 1;
  endtask

  task automatic write_exp(logic sel, logic [5:0] v);
    exp_wr = 1; exp_sel = sel; exp_wdata = v;
    tick();
    exp_wr = 0;
  endtask

  task automatic write_regwen(logic v);
    regwen_wr = 1; regwen_wdata = v;
    tick();
    regwen_wr = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int n, cnt, cnt2;
    // reset state
    repeat (3) tick();
    chk("R5 integ exp reset", integ_exp, 27);
    chk("R5 cons exp reset", cons_exp, 30);
    chk("R6 regwen reset", regwen, 1);
    chk("R4 no req in reset", integ_req | cons_req, 0);
    chk("R9 no alert in reset", integ_alert | cons_alert, 0);
    rst_n = 1;
    repeat (4) tick();

    // table-driven interval checks on the integrity channel
    for (int v = 0; v < NV; v++) begin
      hw_lk = TV_HW[v][0]; sec_lk = TV_SEC[v][0];
      write_exp(1'b0, 6'(TV_EXP[v]));
      wait_req(0, TV_MAX[v] + 4, n);
      chk_rng("R3 first request after restart", n, 1, TV_MAX[v] + 4);
      chk("R7 integ scope", integ_scope, TV_SCOPE[v]);
      for (int g = 0; g < 3; g++) begin
        wait_req(0, TV_MAX[v] + 4, n);
        chk_rng("R2 gap within masked bound", n, TV_MIN[v], TV_MAX[v]);
      end
    end

    // consistency channel: exponent 0, scope with secret locked
    write_exp(1'b1, 6'd0);
    wait_req(1, 6, n);
    chk("R8 cons scope lc+secret", cons_scope, 5);
    wait_req(1, 6, n);
    chk("R3 cons gap with N=0", n, 3);

    // integrity halts with no locked partition; consistency keeps going
    hw_lk = 0; sec_lk = 0;
    cnt = 0; cnt2 = 0;
    for (int k = 0; k < 30; k++) begin
      tick();
      if (integ_req) cnt++;
      if (cons_req) cnt2++;
    end
    chk("R7 integ halted when unlocked", cnt, 0);
    chk_rng("R11 cons keeps running", cnt2, 9, 10);
    wait_req(1, 6, n);
    chk("R8 cons scope lc only", cons_scope, 1);
    hw_lk = 1;
    write_exp(1'b0, 6'd0);
    wait_req(0, 6, n);
    chk_rng("R7 integ resumes on lock", n, 1, 4);
    chk("R7 integ scope hw only", integ_scope, 1);

    // withheld acknowledge
    cons_ack = 0;
    wait_req(1, 6, n);
    tick();
    chk("R4 request is one cycle", cons_req, 0);
    cnt = 0;
    for (int k = 0; k < 20; k++) begin
      tick();
      if (cons_req) cnt++;
    end
    chk("R4 no request without ack", cnt, 0);
    cons_ack = 1;
    wait_req(1, 8, n);
    chk("R3 request three cycles after ack", n, 3);

    // write-enable behaviour
    write_regwen(1'b0);
    chk("R6 write of 0 keeps regwen", regwen, 1);
    write_exp(1'b0, 6'd5);
    chk("R5 exponent writable", integ_exp, 5);
    write_regwen(1'b1);
    chk("R6 regwen cleared", regwen, 0);
    write_exp(1'b0, 6'd9);
    write_exp(1'b1, 6'd12);
    chk("R6 integ exp frozen", integ_exp, 5);
    chk("R6 cons exp frozen", cons_exp, 0);
    wait_req(1, 6, n);
    wait_req(1, 6, n);
    chk("R6 cons gap unchanged after blocked write", n, 3);

    // alerts
    par_err = 1;
    tick();
    chk("R9 parity alert pulse", integ_alert, 1);
    dig_err = 1;
    cnt = 0;
    for (int k = 0; k < 4; k++) begin
      tick();
      if (integ_alert) cnt++;
    end
    chk("R9 no repeat while errors held", cnt, 0);
    par_err = 0; dig_err = 0;
    repeat (2) tick();
    dig_err = 1;
    tick();
    chk("R9 digest alert pulse", integ_alert, 1);
    tick();
    chk("R9 digest alert single cycle", integ_alert, 0);
    dig_err = 0;
    tick();
    cmis = 1;
    cnt = 0; cnt2 = 0;
    for (int k = 0; k < 5; k++) begin
      tick();
      if (cons_alert) cnt++;
      if (integ_alert) cnt2++;
    end
    chk("R10 one consistency alert", cnt, 1);
    chk("R11 integ alert unaffected", cnt2, 0);
    cmis = 0;

    // reset restores write access
    rst_n = 0;
    tick();
    chk("R6 regwen restored by reset", regwen, 1);
    chk("R5 integ exp restored by reset", integ_exp, 27);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule